// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives a slower clock from a fast input clock. A 20-bit setting word holds two 9-bit counts: one sets how many input cycles the output stays high, the other how many it stays low. Their sum is the division ratio, and their balance sets the duty cycle. One extra bit bypasses the divider so that the input clock passes straight through. Another bit ends each high phase half an input cycle early, on a falling input edge, so that odd ratios can still give an even duty cycle.

The setting word may change at any time. The block takes a new word only where one output period ends and the next begins, so the output never shows a shortened pulse. A synchronous reset holds the output low. The first rising input edge after reset is released opens a fresh high phase.

Top module: `pdiv_top`

## Requirements
- R1: The setting word `cfg_i` is laid out as follows: bit 19 is bypass, bit 18 is the odd-trim bit, bits [17:9] are the low count and bits [8:0] are the high count.
- R2: While `rst_i` is sampled high, `clk_o` stays low in both halves of every input cycle, whatever the setting word holds.
- R3: On the first rising `clk_i` edge with `rst_i` low, a high phase begins, so `clk_o` is high during that input cycle.
- R4: With bypass at 0 and the odd-trim bit at 0, `clk_o` is high for exactly H input cycles and then low for exactly L input cycles, repeating with period H+L. For example, 5/5 gives divide-by-10 at 50%, 4/6 gives 40/60, and 2/1 gives divide-by-3 that is high for two thirds of the period.
- R5: A count field of 0 stands for 512 input cycles.
- R6: With bypass at 0 and the odd-trim bit at 1, `clk_o` falls on the falling `clk_i` edge inside the last high cycle. The output is then high for H-½ cycles and low for L+½ cycles. For example, 2/1 gives 1.5/1.5 and 3/2 gives 2.5/2.5.
- R7: With bypass at 1 (outside reset), `clk_o` follows `clk_i`, and the odd-trim bit and both count fields have no effect on it.
- R8: A changed setting word takes effect only at the rising edge that begins a new output period. This applies when switching between two divide settings and when switching into or out of bypass. The period in progress completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 20 | Setting word: bypass, odd-trim, low count, high count |
| clk_o | output | 1 | Divided (or passed-through) clock |

## Verification
The hardest situation to reach from the ports is a setting change that arrives part-way through a period. The output must finish the old period exactly and then switch to the new one without a short pulse. The bench reaches it by writing a new word at a chosen half-cycle index after reset is released. It then compares every half-cycle of `clk_o` against a stream built from whole old periods followed by new ones. It runs this for divide-to-divide, bypass-to-divide and divide-to-bypass changes. The 512-cycle encoding of a zero field needs a run of over a thousand half-cycles, so it gets one long stream of its own.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Default width of each count field
  localparam int DEF_CNT_W = 9;

  // Output phase of the divider
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/pdiv_cfg_hold.sv
// Holds the active setting. It is reloaded during reset and at each period boundary only.
module pdiv_cfg_hold #(
  parameter int CNT_W = pdiv_pkg::DEF_CNT_W,
  localparam int CFG_W = 2 * CNT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] act_o,
  output logic [CNT_W-1:0] lo_o,
  output logic             byp_o,
  output logic             odd_o
);

  logic [CFG_W-1:0] act_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) begin
      act_q <= cfg_i;
    end
  end

  assign act_o = act_q;
  assign byp_o = act_q[CFG_W-1];
  assign odd_o = act_q[CFG_W-2];
  assign lo_o  = act_q[2*CNT_W-1:CNT_W];

endmodule

// File: rtl/pdiv_phase_ctr.sv
// Counts out the high and low phases on rising input edges.
module pdiv_phase_ctr #(
  parameter int CNT_W = pdiv_pkg::DEF_CNT_W,
  localparam int REM_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] nxt_hi_i,
  input  logic [CNT_W-1:0] act_lo_i,
  output logic             phase_hi_o,
  output logic [REM_W-1:0] rem_o,
  output logic             last_hi_o,
  output logic             boundary_o,
  output logic             started_o
);
  import pdiv_pkg::*;

  localparam logic [REM_W-1:0] ONE = REM_W'(1);

  phase_e           phase_q;
  logic [REM_W-1:0] rem_q;
  logic             started_q;
  logic             boundary;

  // A zero field stands for the full 2**CNT_W cycles
  function automatic logic [REM_W-1:0] expand(input logic [CNT_W-1:0] v);
    return {(v == '0), v};
  endfunction

  always_comb begin
    boundary = !started_q || byp_i || ((phase_q == PH_LOW) && (rem_q == ONE));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q   <= PH_LOW;
      rem_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (boundary) begin
        phase_q <= PH_HIGH;
        rem_q   <= expand(nxt_hi_i);
      end else if (rem_q == ONE) begin
        phase_q <= PH_LOW;
        rem_q   <= expand(act_lo_i);
      end else begin
        rem_q <= rem_q - ONE;
      end
    end
  end

  assign phase_hi_o = (phase_q == PH_HIGH);
  assign rem_o      = rem_q;
  assign last_hi_o  = (phase_q == PH_HIGH) && (rem_q == ONE);
  assign boundary_o = boundary;
  assign started_o  = started_q;

endmodule

// File: rtl/pdiv_fall_trim.sv
// Falling-edge register that cuts the final half of the last high cycle.
module pdiv_fall_trim (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic last_hi_i,
  output logic cut_o
);

  logic cut_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      cut_q <= 1'b0;
    end else begin
      cut_q <= en_i && last_hi_i;
    end
  end

  assign cut_o = cut_q;

endmodule

// File: rtl/pdiv_top.sv
module pdiv_top #(
  parameter int CNT_W  = pdiv_pkg::DEF_CNT_W,
  parameter bit ODD_EN = 1'b1,
  localparam int CFG_W = 2 * CNT_W + 2,
  localparam int REM_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             clk_o
);

  logic [CFG_W-1:0] cfg_act;
  logic [CNT_W-1:0] act_lo;
  logic             byp_act;
  logic             odd_act;
  logic             phase_hi;
  logic [REM_W-1:0] rem_q;
  logic             last_hi;
  logic             boundary;
  logic             started;
  logic             cut_q;

  pdiv_cfg_hold #(.CNT_W(CNT_W)) hold_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (boundary),
    .cfg_i  (cfg_i),
    .act_o  (cfg_act),
    .lo_o   (act_lo),
    .byp_o  (byp_act),
    .odd_o  (odd_act)
  );

  pdiv_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .byp_i      (byp_act),
    .nxt_hi_i   (cfg_i[CNT_W-1:0]),
    .act_lo_i   (act_lo),
    .phase_hi_o (phase_hi),
    .rem_o      (rem_q),
    .last_hi_o  (last_hi),
    .boundary_o (boundary),
    .started_o  (started)
  );

  generate
    if (ODD_EN) begin : g_trim
      pdiv_fall_trim trim_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (odd_act && !byp_act),
        .last_hi_i (last_hi),
        .cut_o     (cut_q)
      );
    end else begin : g_no_trim
      assign cut_q = 1'b0;
    end
  endgenerate

  // Bypass passes the input clock once reset has been released
  assign clk_o = byp_act ? (clk_i && started) : (phase_hi && !cut_q);

endmodule

// File: rtl/pdiv_checker.sv
module pdiv_checker #(
  parameter int CNT_W = 9,
  localparam int CFG_W = 2 * CNT_W + 2,
  localparam int REM_W = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CFG_W-1:0] cfg_act,
  input logic             byp_act,
  input logic             odd_act,
  input logic             phase_hi,
  input logic [REM_W-1:0] rem_q,
  input logic             boundary,
  input logic             started,
  input logic             cut_q
);

  // R2
  reset_low_chk: assert property (@(posedge clk_i)
    rst_i |=> (!phase_hi && !started));

  // R3
  first_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |=> phase_hi);

  // R4
  high_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !byp_act && phase_hi && rem_q == REM_W'(1)) |=> !phase_hi);

  // R4
  low_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !byp_act && !phase_hi && rem_q > REM_W'(1)) |=> !phase_hi);

  // R5
  count_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (started && !byp_act) |-> (rem_q != '0));

  // R6
  trim_in_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cut_q |-> (phase_hi && odd_act && !byp_act));

  // R8
  cfg_steady_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !boundary |=> $stable(cfg_act));

endmodule

bind pdiv_top pdiv_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .cfg_act  (cfg_act),
  .byp_act  (byp_act),
  .odd_act  (odd_act),
  .phase_hi (phase_hi),
  .rem_q    (rem_q),
  .boundary (boundary),
  .started  (started),
  .cut_q    (cut_q)
);

// File: tb/pdiv_top_tb_top.sv
module pdiv_top_tb_top;

  localparam int CLK_P = 10;
  localparam int MAXH  = 4096;

  logic        clk;
  logic        rst;
  logic [19:0] cfg;
  logic        clk_o;

  int n_chk = 0;
  int n_bad = 0;

  bit exp_q [MAXH];
  int exp_n;

  pdiv_top dut_i (
    .clk_i (clk),
    .rst_i (rst),
    .cfg_i (cfg),
    .clk_o (clk_o)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // R1 layout: [19] bypass, [18] odd-trim, [17:9] low, [8:0] high
  function automatic logic [19:0] mk(input bit byp, input bit odd, input int lo, input int hi);
    return {byp, odd, 9'(lo), 9'(hi)};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 512 : v;
  endfunction

  task automatic push_div(input int hi, input int lo, input bit odd, input int periods);
    int n2, hh;
    n2 = 2 * (eff(hi) + eff(lo));
    hh = 2 * eff(hi) - (odd ? 1 : 0);
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < n2; i++) begin
        exp_q[exp_n] = (i < hh);
        exp_n++;
      end
    end
  endtask

  task automatic push_byp(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      exp_q[exp_n] = 1'b1;
      exp_q[exp_n + 1] = 1'b0;
      exp_n += 2;
    end
  endtask

  // Reset, release, then compare each half-cycle with exp_q
  task automatic run_stream(input logic [19:0] cfg_a, input int change_at,
                            input logic [19:0] cfg_b, input string req);
    int  bad, first;
    bit  got_first, exp_first;
    bad = 0; first = -1; got_first = 0; exp_first = 0;
    cfg = cfg_a;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    for (int k = 0; k < exp_n; k++) begin
      if (k % 2 == 0) @(posedge clk);
      else            @(negedge clk);
      #2;
      if (clk_o !== exp_q[k]) begin
        if (first < 0) begin
          first = k; got_first = clk_o; exp_first = exp_q[k];
        end
        bad++;
      end
      if (k == change_at) cfg = cfg_b;
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: %0d half-cycles differ, first at %0d actual=%0b expected=%0b",
               req, bad, first, got_first, exp_first);
    end
  endtask

  task automatic t_reset();
    int bad;
    bad = 0;
    cfg = mk(1, 0, 1, 1);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) @(posedge clk);
      else            @(negedge clk);
      #2;
      if (clk_o !== 1'b0) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL R2: output high during reset in %0d halves actual=1 expected=0", bad);
    end
  endtask

  task automatic t_div(input int hi, input int lo, input bit odd, input int periods, input string req);
    exp_n = 0;
    push_div(hi, lo, odd, periods);
    run_stream(mk(0, odd, lo, hi), -1, '0, req);
  endtask

  task automatic t_byp(input bit odd, input int lo, input int hi);
    exp_n = 0;
    push_byp(12);
    run_stream(mk(1, odd, lo, hi), -1, '0, "R7 bypass");
  endtask

  task automatic t_div_to_div();
    exp_n = 0;
    push_div(5, 5, 0, 1);
    push_div(2, 1, 0, 3);
    run_stream(mk(0, 0, 5, 5), 4, mk(0, 0, 1, 2), "R8 div-to-div");
  endtask

  task automatic t_byp_to_div();
    exp_n = 0;
    push_byp(4);
    push_div(4, 6, 0, 2);
    run_stream(mk(1, 0, 0, 0), 6, mk(0, 0, 6, 4), "R8 bypass-to-div");
  endtask

  task automatic t_div_to_byp();
    exp_n = 0;
    push_div(2, 1, 1, 1);
    push_byp(5);
    run_stream(mk(0, 1, 1, 2), 0, mk(1, 0, 0, 0), "R8 div-to-bypass");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg = '0;
    t_reset();                              // R2
    t_div(5, 5, 0, 3, "R3 R4 5/5");         // first half-cycle high after release
    t_div(4, 6, 0, 3, "R4 4/6");
    t_div(2, 1, 0, 4, "R4 2/1");
    t_div(0, 1, 0, 2, "R5 zero high count");
    t_div(1, 0, 0, 2, "R5 zero low count");
    t_div(2, 1, 1, 4, "R6 odd 2/1");
    t_div(3, 2, 1, 3, "R6 odd 3/2");
    t_div(3, 3, 1, 3, "R6 odd 3/3");
    t_div(1, 1, 1, 4, "R6 odd 1/1");
    t_byp(1, 7, 0);                         // R7 other fields ignored
    t_byp(0, 2, 3);                         // R7
    t_div_to_div();                         // R8
    t_byp_to_div();                         // R8
    t_div_to_byp();                         // R8
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule